// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block walks a horizontal pixel counter and a vertical line counter across a raster whose geometry is entirely programmable, and derives from them the horizontal and vertical sync pins, a composite sync for the green channel, the active-video enable and a one-cycle line-prefetch pulse that warns the pixel pipeline a fixed number of clocks before a line ends. Every geometry register holds the last count value of its span, so a 10-pixel line is programmed as 9.

Software programs the geometry through a simple write port while the generator is stopped, or while it runs. Geometry written during a frame is held in shadow registers and becomes active only when the frame completes, so a frame is never torn. Polarity, per-sync disable, sync-on-green and a display-off blanking control act on the very next clock, which suits monitor power management. Nothing in the block is a data stream, so every pin is a plain level or pulse with no handshake.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal counter counts 0 up to the value in the horizontal-last register (address 1), then returns to 0, so a line lasts that value plus one clock.
- R2: The vertical counter advances by one only on the clock where the horizontal counter returns to 0, and itself returns to 0 after the vertical-last value (address 5).
- R3: The raw horizontal sync is active while the horizontal count lies between the sync-begin (address 3) and sync-end (address 4) values inclusive; the raw vertical sync follows the same rule on lines with addresses 7 and 8.
- R4: Control register (address 0) bit 0 runs the generator; while it is clear both counters sit at 0, the raw syncs are inactive, and video enable and prefetch stay low. After reset all outputs and counters are 0.
- R5: Video enable is high only when control bit 1 (refresh) is set, the horizontal count is at most the horizontal visible-last value (address 2) and the vertical count is at most the vertical visible-last value (address 6).
- R6: The prefetch output pulses for exactly one clock per line, when the horizontal count equals the prefetch position (address 9).
- R7: Sync-control register (address 10) bit 3 inverts the horizontal sync pin and bit 4 inverts the vertical sync pin.
- R8: Sync-control bit 5 holds the horizontal sync pin and bit 6 the vertical sync pin at its inactive level (the value of its invert bit); bit 1 does this for both.
- R9: The green-sync output carries the logical OR of the raw syncs when sync-control bit 0 is set and bit 1 is clear, and is 0 otherwise.
- R10: Display-control register (address 11) bit 1 forces video enable low while the counters keep running.
- R11: Geometry registers (addresses 1 to 9) written while running take effect from the clock after both counters return to 0; while stopped they take effect one clock after the write. Control, sync-control and display-control writes act one clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | CW (12) | Register write data |
| h_count | output | CW (12) | Horizontal pixel count |
| v_count | output | CW (12) | Vertical line count |
| hsync | output | 1 | Horizontal sync pin after polarity and disable |
| vsync | output | 1 | Vertical sync pin after polarity and disable |
| green_sync | output | 1 | Composite sync for the green channel |
| video_en | output | 1 | Active-video enable |
| line_prefetch | output | 1 | One-clock early-fetch pulse per line |

## Verification
All pin outputs are combinational from the counter and configuration registers, so they are due in the same clock in which the counters show the position concerned, and any register write shows its effect one clock after the write edge, or for geometry written while running, one clock after the frame-closing edge. The bench keeps its own cycle model updated on the rising edge from its own stimulus, and compares every output against it at the falling edge, so each check lands exactly where the due cycle falls. Count-based checks over whole frames (prefetch pulses, sync and enable widths) and a check that a mid-frame geometry change stays invisible until the frame ends add timing-independent evidence.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  // geometry slots; register address is slot + 1
  localparam int unsigned SLOT_H_LAST = 0;
  localparam int unsigned SLOT_H_VIS  = 1;
  localparam int unsigned SLOT_H_SB   = 2;
  localparam int unsigned SLOT_H_SE   = 3;
  localparam int unsigned SLOT_V_LAST = 4;
  localparam int unsigned SLOT_V_VIS  = 5;
  localparam int unsigned SLOT_V_SB   = 6;
  localparam int unsigned SLOT_V_SE   = 7;
  localparam int unsigned SLOT_H_PF   = 8;
  localparam int unsigned NSLOT       = 9;

  localparam logic [3:0] ADR_CTRL = 4'd0;
  localparam logic [3:0] ADR_SYNC = 4'd10;
  localparam logic [3:0] ADR_DISP = 4'd11;

  localparam int unsigned SYNC_W      = 7;
  localparam int unsigned SB_GREEN    = 0;
  localparam int unsigned SB_ALL_OFF  = 1;
  localparam int unsigned SB_H_INV    = 3;
  localparam int unsigned SB_V_INV    = 4;
  localparam int unsigned SB_H_OFF    = 5;
  localparam int unsigned SB_V_OFF    = 6;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [3:0]                  addr,
  input  logic [CW-1:0]               wdata,
  input  logic                        frame_edge,
  output logic                        run,
  output logic                        refresh,
  output logic                        disp_off,
  output logic [SYNC_W-1:0]           sync_cfg,
  output logic [NSLOT-1:0][CW-1:0]    act
);
  logic [NSLOT-1:0][CW-1:0] shadow;

  // shadow copies, one per geometry slot
  for (genvar i = 0; i < NSLOT; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow[i] <= '0;
      else if (wr && addr == 4'(i + 1))
        shadow[i] <= wdata;
    end
  end

  // active geometry follows shadow while stopped, else only at frame end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act <= '0;
    else if (!run || frame_edge)
      act <= shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      refresh  <= 1'b0;
      disp_off <= 1'b0;
      sync_cfg <= '0;
    end else if (wr) begin
      if (addr == ADR_CTRL) begin
        run     <= wdata[0];
        refresh <= wdata[1];
      end
      if (addr == ADR_SYNC) sync_cfg <= wdata[SYNC_W-1:0];
      if (addr == ADR_DISP) disp_off <= wdata[1];
    end
  end

  AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_edge) |=> $stable(act)); // R11
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] last,
  input  logic [CW-1:0] vis_last,
  input  logic [CW-1:0] sync_beg,
  input  logic [CW-1:0] sync_end,
  output logic [CW-1:0] count,
  output logic          wrap,
  output logic          in_vis,
  output logic          in_sync
);
  assign wrap    = run && step && (count == last);
  assign in_vis  = (count <= vis_last);
  assign in_sync = (count >= sync_beg) && (count <= sync_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (!run)
      count <= '0;
    else if (step)
      count <= (count == last) ? '0 : count + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= last); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && count == last) |=> (count == '0)); // R1
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !step) |=> $stable(count)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0)); // R4
endmodule

// File: rtl/dtg_sync_pin.sv
module dtg_sync_pin (
  input  logic raw,
  input  logic inv,
  input  logic off,
  output logic pin
);
  // a disabled pin rests at its inactive level after polarity
  assign pin = off ? inv : (raw ^ inv);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] h_count,
  output logic [CW-1:0] v_count,
  output logic          hsync,
  output logic          vsync,
  output logic          green_sync,
  output logic          video_en,
  output logic          line_prefetch
);
  localparam int NAX = 2;

  logic                     run, refresh, disp_off;
  logic [SYNC_W-1:0]        sync_cfg;
  logic [NSLOT-1:0][CW-1:0] act;
  logic                     h_wrap, v_wrap, h_vis, v_vis, h_sy, v_sy;
  logic                     frame_edge;
  logic [NAX-1:0]           raw, inv, off, pins;

  assign frame_edge = h_wrap && v_wrap;

  dtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .frame_edge(frame_edge), .run(run), .refresh(refresh), .disp_off(disp_off),
    .sync_cfg(sync_cfg), .act(act)
  );

  dtg_axis #(.CW(CW)) u_hax (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
    .last(act[SLOT_H_LAST]), .vis_last(act[SLOT_H_VIS]),
    .sync_beg(act[SLOT_H_SB]), .sync_end(act[SLOT_H_SE]),
    .count(h_count), .wrap(h_wrap), .in_vis(h_vis), .in_sync(h_sy)
  );

  dtg_axis #(.CW(CW)) u_vax (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap),
    .last(act[SLOT_V_LAST]), .vis_last(act[SLOT_V_VIS]),
    .sync_beg(act[SLOT_V_SB]), .sync_end(act[SLOT_V_SE]),
    .count(v_count), .wrap(v_wrap), .in_vis(v_vis), .in_sync(v_sy)
  );

  assign raw = {run && v_sy, run && h_sy};
  assign inv = {sync_cfg[SB_V_INV], sync_cfg[SB_H_INV]};
  assign off = {sync_cfg[SB_V_OFF] | sync_cfg[SB_ALL_OFF],
                sync_cfg[SB_H_OFF] | sync_cfg[SB_ALL_OFF]};

  for (genvar a = 0; a < NAX; a++) begin : g_pin
    dtg_sync_pin u_pin (.raw(raw[a]), .inv(inv[a]), .off(off[a]), .pin(pins[a]));
  end

  assign hsync         = pins[0];
  assign vsync         = pins[1];
  assign green_sync    = sync_cfg[SB_GREEN] && !sync_cfg[SB_ALL_OFF] && (|raw);
  assign video_en      = run && refresh && !disp_off && h_vis && v_vis;
  assign line_prefetch = run && (h_count == act[SLOT_H_PF]);

  AST_DE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    video_en |-> (h_count <= act[SLOT_H_VIS] && v_count <= act[SLOT_V_VIS])); // R5
  AST_V_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && h_count != act[SLOT_H_LAST]) |=> $stable(v_count)); // R2
endmodule

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] h_count, v_count;
  logic          hsync, vsync, green_sync, video_en, line_prefetch;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  disp_timing_gen #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .h_count(h_count), .v_count(v_count),
    .hsync(hsync), .vsync(vsync), .green_sync(green_sync),
    .video_en(video_en), .line_prefetch(line_prefetch)
  );

  // ---------------- reference model from the requirements ----------------
  int m_sh[9];
  int m_act[9];
  bit m_run, m_ref, m_doff;
  bit [6:0] m_sync;
  int mh, mv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) begin m_sh[i] <= 0; m_act[i] <= 0; end
      m_run <= 0; m_ref <= 0; m_doff <= 0; m_sync <= '0; mh <= 0; mv <= 0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == 0) begin m_run <= reg_wdata[0]; m_ref <= reg_wdata[1]; end
        else if (reg_addr == 10) m_sync <= reg_wdata[6:0];
        else if (reg_addr == 11) m_doff <= reg_wdata[1];
        else if (reg_addr >= 1 && reg_addr <= 9) m_sh[reg_addr-1] <= int'(reg_wdata);
      end
      if (!m_run) begin
        mh <= 0; mv <= 0; m_act <= m_sh;
      end else if (mh == m_act[0]) begin
        mh <= 0;
        if (mv == m_act[4]) begin mv <= 0; m_act <= m_sh; end
        else mv <= mv + 1;
      end else mh <= mh + 1;
    end
  end

  function automatic logic [30:0] expect_vec();
    bit hr, vr, hs, vs, g, de, pf;
    hr = m_run && mh >= m_act[2] && mh <= m_act[3];
    vr = m_run && mv >= m_act[6] && mv <= m_act[7];
    hs = (m_sync[5] || m_sync[1]) ? m_sync[3] : (hr ^ m_sync[3]);
    vs = (m_sync[6] || m_sync[1]) ? m_sync[4] : (vr ^ m_sync[4]);
    g  = m_sync[0] && !m_sync[1] && (hr || vr);
    de = m_run && m_ref && !m_doff && mh <= m_act[1] && mv <= m_act[5];
    pf = m_run && mh == m_act[8];
    return {12'(mh), 12'(mv), hs, vs, g, de, pf, 2'b00};
  endfunction

  function automatic logic [30:0] actual_vec();
    return {h_count, v_count, hsync, vsync, green_sync, video_en, line_prefetch, 2'b00};
  endfunction

  task automatic chk(string req, string what, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  // compare all outputs against the model for n cycles
  task automatic run_cmp(string req, int n);
    int bad = 0;
    logic [30:0] a, e, fa, fe;
    fa = '0; fe = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      a = actual_vec(); e = expect_vec();
      if (a != e && bad == 0) begin fa = a; fe = e; end
      if (a != e) bad++;
    end
    checks++;
    if (bad != 0) begin
      failures++;
      $display("FAIL %s output vector actual=%h expected=%h (%0d cycles off)", req, fa, fe, bad);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = CW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic program_small();
    wr(0, 0);
    wr(1, 9); wr(2, 5); wr(3, 6); wr(4, 7);
    wr(5, 6); wr(6, 3); wr(7, 4); wr(8, 5); wr(9, 7);
    wr(10, 0); wr(11, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk("R4", "h_count after reset", int'(h_count), 0);
    chk("R4", "v_count after reset", int'(v_count), 0);
    chk("R4", "pins after reset", int'({hsync, vsync, green_sync, video_en, line_prefetch}), 0);
  endtask

  task automatic t_basic();
    int npf = 0, nhs = 0, nde = 0;
    program_small();
    wr(0, 3);
    run_cmp("R1 R2 R3", 140);
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      npf += int'(line_prefetch); nhs += int'(hsync); nde += int'(video_en);
    end
    chk("R6", "prefetch pulses per frame", npf, 7);
    chk("R3", "hsync clocks per frame", nhs, 14);
    chk("R5", "video enable clocks per frame", nde, 24);
  endtask

  task automatic t_polarity();
    wr(10, 'h18);
    run_cmp("R7", 140);
  endtask

  task automatic t_off();
    int hs_hi = 0, vs_ch = 0;
    wr(10, 'h28);
    run_cmp("R8", 70);
    for (int k = 0; k < 70; k++) begin
      @(negedge clk); hs_hi += int'(hsync);
    end
    chk("R8", "inverted disabled hsync stays high", hs_hi, 70);
    wr(10, 'h02);
    for (int k = 0; k < 70; k++) begin
      @(negedge clk); vs_ch += int'(vsync) + int'(hsync);
    end
    chk("R8", "all-off keeps both syncs low", vs_ch, 0);
    run_cmp("R8", 70);
  endtask

  task automatic t_green();
    int ng = 0;
    wr(10, 'h01);
    run_cmp("R9", 70);
    for (int k = 0; k < 70; k++) begin @(negedge clk); ng += int'(green_sync); end
    // 2 lines of vsync (20 clocks) plus hsync on 5 other lines (10 clocks)
    chk("R9", "green sync clocks per frame", ng, 30);
    wr(10, 'h03);
    run_cmp("R9", 70);
    wr(10, 0);
  endtask

  task automatic t_dispoff();
    int nde = 0;
    logic [CW-1:0] h0;
    wr(11, 2);
    h0 = h_count;
    for (int k = 0; k < 70; k++) begin @(negedge clk); nde += int'(video_en); end
    chk("R10", "video enable while display off", nde, 0);
    chk("R10", "counter still moving", int'(h_count != h0 || v_count != 0), 1);
    run_cmp("R10", 35);
    wr(11, 0);
    wr(0, 1);
    run_cmp("R5", 70);
    wr(0, 3);
  endtask

  task automatic t_reprog();
    bit frame_done = 0, early = 0, seen = 0;
    logic [CW-1:0] pv;
    // wait until mid-frame
    while (!(v_count == 2)) @(negedge clk);
    wr(1, 13);
    pv = v_count;
    for (int k = 0; k < 250; k++) begin
      @(negedge clk);
      if (pv != 0 && v_count == 0) frame_done = 1;
      if (h_count > 9 && !frame_done) early = 1;
      if (h_count == 13 && frame_done) seen = 1;
      pv = v_count;
    end
    chk("R11", "new line length seen before frame end", int'(early), 0);
    chk("R11", "new line length used after frame end", int'(seen), 1);
    run_cmp("R11", 200);
  endtask

  task automatic t_disable();
    wr(0, 0);
    @(negedge clk);
    chk("R4", "h_count when stopped", int'(h_count), 0);
    chk("R4", "v_count when stopped", int'(v_count), 0);
    run_cmp("R4", 20);
    wr(1, 4);
    @(negedge clk);
    wr(0, 1);
    run_cmp("R11", 60);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_polarity();
    t_off();
    t_green();
    t_dispoff();
    t_reprog();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule